// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full double-width product of two unsigned operands by stepping once per clock through the bits of one of them. A start request, taken only while the block is idle, loads both operands and clears the product. Each of the following OP_W clock cycles is one iteration. In each iteration the low bit of the multiplier decides whether the current multiplicand value is added into a fixed accumulator. In the same cycle the multiplicand moves one place left inside a double-width register and the multiplier moves one place right.

A single-cycle done pulse marks the end of the operation, and busy falls in that same cycle. The product output then holds the result until the next accepted start. A start that arrives while an operation is running is dropped and does not disturb it.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, busy and done are 0 and product is 0.
- R2: When start is 1 and busy is 0 at a rising edge, busy is 1 and product is 0 after that edge.
- R3: After an accepted start, busy stays 1 for exactly OP_W rising edges and falls on the OP_W-th edge after the start edge.
- R4: done is 1 for exactly the one cycle in which busy has just fallen. It is never 1 in two consecutive cycles.
- R5: While done is 1, product equals the full 2*OP_W-bit unsigned product of the operands captured at the accepted start.
- R6: While busy is 0 and no start is accepted, product does not change, whatever the operand inputs do.
- R7: A start raised while busy is 1 is ignored. The running operation keeps its operands and its timing.
- R8: A zero operand gives a zero product. Two all-ones operands give (2^OP_W-1)^2.
- R9: After k iterations (1 <= k <= OP_W), product equals op_a times the low k bits of op_b. Bit i of op_b adds op_a shifted left by i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiplication (taken only when idle) |
| op_a | input | OP_W | Multiplicand |
| op_b | input | OP_W | Multiplier |
| product | output | 2*OP_W | Accumulated product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is final |

## Verification
The assertions check the busy and done sequence on every cycle. They cover the OP_W-edge busy window counted by a checker counter, the single-cycle done pulse, and the hold of the product while idle. On every done pulse they also compare the product with a product of the operands captured at the accepted start, which covers a start ignored mid-run. Only the bench scenarios show the partial sums after a given number of iterations, the result of corner operand patterns such as zero, all-ones and alternating bits, and that changing the operand inputs while idle leaves the output untouched.

// File: rtl/mul_pkg.sv
package mul_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mul_state_e;
endpackage

// File: rtl/mul_sequencer.sv
module mul_sequencer
   import mul_pkg::*;
#(
   parameter int ITER = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

   mul_state_e       state_q;
   logic [CNT_W-1:0] iter_q;
   logic             done_q;
   logic             last_iter;

   assign load      = start && (state_q == ST_IDLE);
   assign step      = (state_q == ST_RUN);
   assign last_iter = step && (iter_q == LAST);
   assign busy      = step;
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_iter;
         if (load) begin
            state_q <= ST_RUN;
            iter_q  <= '0;
         end else if (step) begin
            iter_q <= iter_q + 1'b1;
            if (last_iter) state_q <= ST_IDLE;
         end
      end
   end
endmodule

// File: rtl/mul_operand_regs.sv
module mul_operand_regs #(
   parameter int OP_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [OP_W-1:0]   a_in,
   input  logic [OP_W-1:0]   b_in,
   output logic [2*OP_W-1:0] mcand,
   output logic              mplier_lsb
);
   localparam int PW = 2 * OP_W;

   logic [PW-1:0]   mcand_q;
   logic [OP_W-1:0] mplier_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
      end else if (load) begin
         mcand_q  <= {{OP_W{1'b0}}, a_in};
         mplier_q <= b_in;
      end else if (step) begin
         mcand_q  <= {mcand_q[PW-2:0], 1'b0};
         mplier_q <= {1'b0, mplier_q[OP_W-1:1]};
      end
   end

   assign mcand      = mcand_q;
   assign mplier_lsb = mplier_q[0];
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
   parameter int PW    = 64,
   parameter int SEG_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          add_en,
   input  logic [PW-1:0] addend,
   output logic [PW-1:0] acc
);
   localparam int NSEG = (SEG_W >= PW) ? 1 : PW / SEG_W;

   logic [PW-1:0] acc_q;
   logic [PW-1:0] sum;

   generate
      if (NSEG == 1) begin : g_flat
         assign sum = acc_q + addend;
      end else begin : g_seg
         logic [NSEG:0] carry;
         assign carry[0] = 1'b0;
         for (genvar s = 0; s < NSEG; s++) begin : g_lane
            logic [SEG_W:0] part;
            assign part = {1'b0, acc_q[s*SEG_W +: SEG_W]}
                        + {1'b0, addend[s*SEG_W +: SEG_W]}
                        + {{SEG_W{1'b0}}, carry[s]};
            assign sum[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
            assign carry[s+1] = part[SEG_W];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clear)  acc_q <= '0;
      else if (add_en) acc_q <= sum;
   end

   assign acc = acc_q;
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
   parameter int OP_W  = 32,
   parameter int SEG_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [2*OP_W-1:0] product,
   output logic              busy,
   output logic              done
);
   localparam int PW = 2 * OP_W;

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("shiftadd_mul: OP_W must be at least 2");
      end
      if (SEG_W < PW && (PW % SEG_W) != 0) begin : g_bad_seg
         $error("shiftadd_mul: SEG_W must divide 2*OP_W");
      end
   endgenerate

   logic          load, step, lsb;
   logic [PW-1:0] mcand;

   mul_sequencer #(.ITER(OP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .busy(busy), .done(done)
   );

   mul_operand_regs #(.OP_W(OP_W)) u_ops (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .a_in(op_a), .b_in(op_b), .mcand(mcand), .mplier_lsb(lsb)
   );

   mul_accum #(.PW(PW), .SEG_W(SEG_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(load), .add_en(step && lsb),
      .addend(mcand), .acc(product)
   );
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
   parameter int OP_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [OP_W-1:0]   op_a,
   input logic [OP_W-1:0]   op_b,
   input logic [2*OP_W-1:0] product,
   input logic              busy,
   input logic              done
);
   localparam int PW  = 2 * OP_W;
   localparam int BCW = $clog2(OP_W) + 2;

   logic [BCW-1:0]  run_cnt;
   logic [OP_W-1:0] cap_a, cap_b;
   logic [PW-1:0]   ref_prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         cap_a   <= '0;
         cap_b   <= '0;
      end else if (start && !busy) begin
         run_cnt <= '0;
         cap_a   <= op_a;
         cap_b   <= op_b;
      end else if (busy) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   assign ref_prod = {{OP_W{1'b0}}, cap_a} * {{OP_W{1'b0}}, cap_b};

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && product == '0));

   p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == BCW'(OP_W)));

   p_single_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == ref_prod));

   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

bind shiftadd_mul mul_checker #(.OP_W(OP_W)) u_mul_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
   .product(product), .busy(busy), .done(done)
);

// File: tb/test_shiftadd_mul.sv
module test_shiftadd_mul;
   localparam int W  = 32;
   localparam int PW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0;
   logic [PW-1:0] product;
   logic          busy, done;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   shiftadd_mul #(.OP_W(W)) i_shiftadd_mul (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .product(product), .busy(busy), .done(done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 50000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run did not finish, cycles=%0d expected<50000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [PW-1:0] mulref(input logic [W-1:0] a, input logic [W-1:0] b);
      return {{W{1'b0}}, a} * {{W{1'b0}}, b};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                      input logic [PW-1:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // runs one multiplication; optionally raises start again mid-run (R7)
   task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
      logic [PW-1:0] exp;
      int timing_err;
      exp = mulref(a, b);
      timing_err = 0;
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", PW'(busy), 64'd1);
      chk(product == '0, "R2 product cleared", product, '0);
      for (int k = 1; k <= W; k++) begin
         @(negedge clk);
         if (busy != (k < W) || done != (k == W)) timing_err++;
         if (k == 8)
            chk(product == mulref(a, b & 32'h0000_00ff), "R9 partial after 8", product,
                mulref(a, b & 32'h0000_00ff));
         if (k == 16)
            chk(product == mulref(a, b & 32'h0000_ffff), "R9 partial after 16", product,
                mulref(a, b & 32'h0000_ffff));
         if (intrude && k == 5) begin
            op_a = ~a; op_b = b ^ 32'h1234_5678; start = 1'b1;
         end
         if (intrude && k == 6) start = 1'b0;
      end
      chk(timing_err == 0, "R3 busy/done window", PW'(timing_err), '0);
      chk(product == exp, intrude ? "R7 result unchanged by mid-run start" : "R5 final product",
          product, exp);
      @(negedge clk);
      chk(done == 1'b0, "R4 done lasts one cycle", PW'(done), '0);
      chk(product == exp, "R6 product held after done", product, exp);
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1 busy at reset", PW'(busy), '0);
      chk(done == 1'b0, "R1 done at reset", PW'(done), '0);
      chk(product == '0, "R1 product at reset", product, '0);
   endtask

   task automatic t_idle_hold();
      logic [PW-1:0] held;
      held = product;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         op_a = op_a + 32'h0101_0101;
         op_b = op_b ^ 32'hffff_0000;
      end
      @(negedge clk);
      chk(product == held && !busy, "R6 idle hold with changing inputs", product, held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_mul(32'd13, 32'd9, 1'b0);
      run_mul(32'h0000_004d, 32'h0000_0017, 1'b0);
      run_mul(32'h0, 32'hdead_beef, 1'b0);                 // R8 zero multiplicand
      chk(product == '0, "R8 zero operand a", product, '0);
      run_mul(32'hcafe_f00d, 32'h0, 1'b0);                 // R8 zero multiplier
      chk(product == '0, "R8 zero operand b", product, '0);
      run_mul(32'hffff_ffff, 32'hffff_ffff, 1'b0);         // R8 all ones
      chk(product == 64'hffff_fffe_0000_0001, "R8 all-ones product", product,
          64'hffff_fffe_0000_0001);
      run_mul(32'haaaa_aaaa, 32'h5555_5555, 1'b0);
      run_mul(32'h1, 32'hffff_ffff, 1'b0);
      run_mul(32'h8000_0000, 32'h8000_0001, 1'b0);
      t_idle_hold();
      run_mul(32'h1357_9bdf, 32'h2468_ace0, 1'b1);         // R7 start while busy
      run_mul(32'h7fff_ffff, 32'h0000_0003, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule